// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the frame timing for a parallel RGB panel from a single pixel clock. It drives a vertical sync strobe, a horizontal sync strobe and a data-enable strobe, and it also reports the current pixel column, line index and field. The horizontal counter runs freely over the programmed line length. The vertical timing is counted in pixel clocks from the start of each frame. Because of this, a frame may end in the middle of a line, and that is how the half-line option produces alternating fields. A launch-edge select output tells a downstream output register which dot-clock edge to launch pixel data on.

All timing values arrive as static configuration inputs. They are captured into shadow registers only in the load cycle after a reset and in the cycle that closes a frame, so a change in the middle of a frame cannot cut a pulse short. The vertical pulse width and the vertical period each have their own unit select. A 0 counts in pixel clocks and a 1 counts in whole lines. Every strobe has its own polarity bit, and the data-enable strobe can be disabled.

Top module: `rgb_timing_gen`

## Requirements
- R1: After `rst_ni` is released, or in the cycle after `clr_i` is sampled high, there is exactly one load cycle. In that cycle `px_x_o` and `line_y_o` are 0 and all three strobes sit at their inactive level. The following cycle is pixel 0 of a new frame.
- R2: `px_x_o` counts 0, 1, …, H-1 and wraps to 0, where H is the captured `h_total_i`. `hsync` is active while `px_x_o` < the captured `h_sync_w_i`.
- R3: With `vs_w_unit_i`=0, `vsync` is active during the first `v_sync_w_i` pixel clocks of each frame.
- R4: With `vs_w_unit_i`=1, `vsync` is active during the first `v_sync_w_i`×H pixel clocks of each frame.
- R5: The frame length in pixel clocks is `v_total_i` when `v_total_unit_i`=0, and `v_total_i`×H when it is 1.
- R6: With `half_line_i`=1, the frame length is increased by floor(H/2). `px_x_o` is not reset at a frame start, so successive frames begin alternately at mid-line and at line start. `field_o` toggles at each frame start while half-line is captured, and it is 0 while half-line is not captured.
- R7: `line_y_o` increments when `px_x_o` wraps and returns to 0 at each frame start. If both happen in the same cycle, the frame start wins.
- R8: Data-enable is active when all of the following hold: `de_en_i` is captured as 1; `px_x_o` is in [h_sync_w+h_bp, h_sync_w+h_bp+h_act); and `line_y_o` is in [v_bp, v_bp+v_act).
- R9: For each strobe, the pin is high when the strobe is active if its polarity bit is 1, and low when active if the bit is 0. Polarity bit 0 is the default and means active low.
- R10: While `de_en_i` is captured as 0, `de_o` is held at its inactive level, which is the inverse of the data-enable polarity bit.
- R11: `launch_rise_o` equals the captured `clk_pol_i`. Value 0 means data is launched on the falling dot-clock edge and captured on the rising edge. Value 1 swaps the two edges.
- R12: Configuration inputs are captured only in the load cycle and in the last cycle of a frame. A change at any other time has no effect on any output until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous restart of the frame |
| h_total_i | input | HW | Line length in pixel clocks |
| h_sync_w_i | input | HW | Horizontal sync width in pixel clocks |
| h_bp_i | input | HW | Pixels between sync end and active start |
| h_act_i | input | HW | Active pixels per line |
| v_total_i | input | VW | Frame length, unit chosen by v_total_unit_i |
| v_sync_w_i | input | VW | Vertical sync width, unit chosen by vs_w_unit_i |
| v_bp_i | input | VW | First active line, counted from the frame start |
| v_act_i | input | VW | Active lines per frame |
| v_total_unit_i | input | 1 | 0: pixel clocks, 1: lines |
| vs_w_unit_i | input | 1 | 0: pixel clocks, 1: lines |
| half_line_i | input | 1 | Adds half a line to each frame |
| vs_pol_i | input | 1 | Vertical sync polarity, 1 = active high |
| hs_pol_i | input | 1 | Horizontal sync polarity, 1 = active high |
| de_pol_i | input | 1 | Data-enable polarity, 1 = active high |
| clk_pol_i | input | 1 | Launch edge select, 1 = rising |
| de_en_i | input | 1 | Enables the data-enable strobe |
| vsync_o | output | 1 | Vertical sync pin |
| hsync_o | output | 1 | Horizontal sync pin |
| de_o | output | 1 | Data-enable pin |
| launch_rise_o | output | 1 | Launch edge select for the output register |
| px_x_o | output | HW | Current pixel column |
| line_y_o | output | VW | Current line index within the frame |
| field_o | output | 1 | Field parity in half-line mode |

## Verification
A line wrap and a frame start can land on the same cycle. This always happens when the frame length is a whole number of lines, and it never happens on alternate frames in half-line mode. The bench runs line-unit frames so that every frame start coincides with a wrap. It then runs half-line frames so that starts fall mid-line, and mixes in random configurations. In each case it judges from `line_y_o` that the frame start takes priority. It also checks that the pixel column carries through the frame start without a jump.

// File: rtl/rgb_tg_pkg.sv
package rgb_tg_pkg;
  typedef struct packed {
    logic vs_pol;
    logic hs_pol;
    logic de_pol;
    logic clk_pol;
    logic de_en;
    logic half;
  } tg_flags_t;

  localparam int unsigned NSTROBE = 3;
  localparam int unsigned IDX_VS = 0;
  localparam int unsigned IDX_HS = 1;
  localparam int unsigned IDX_DE = 2;
endpackage

// File: rtl/rgb_tg_shadow.sv
module rgb_tg_shadow
  import rgb_tg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11,
  localparam int unsigned PW = HW + VW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [HW-1:0] h_total_i,
  input  logic [HW-1:0] h_sync_w_i,
  input  logic [HW-1:0] h_bp_i,
  input  logic [HW-1:0] h_act_i,
  input  logic [VW-1:0] v_total_i,
  input  logic [VW-1:0] v_sync_w_i,
  input  logic [VW-1:0] v_bp_i,
  input  logic [VW-1:0] v_act_i,
  input  logic          v_total_unit_i,
  input  logic          vs_w_unit_i,
  input  tg_flags_t     flags_i,
  output logic [HW-1:0] ht_o,
  output logic [HW-1:0] hsw_o,
  output logic [HW-1:0] hbp_o,
  output logic [HW-1:0] hact_o,
  output logic [VW-1:0] vbp_o,
  output logic [VW-1:0] vact_o,
  output logic [PW-1:0] per_o,
  output logic [PW-1:0] pul_o,
  output tg_flags_t     flags_o
);
  logic [PW-1:0] per_d, pul_d, half_add;

  // vertical values converted to pixel clocks at capture time
  always_comb begin
    half_add = flags_i.half ? PW'(h_total_i >> 1) : '0;
    per_d    = (v_total_unit_i ? PW'(v_total_i) * PW'(h_total_i) : PW'(v_total_i)) + half_add;
    pul_d    = vs_w_unit_i ? PW'(v_sync_w_i) * PW'(h_total_i) : PW'(v_sync_w_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ht_o <= '0; hsw_o <= '0; hbp_o <= '0; hact_o <= '0;
      vbp_o <= '0; vact_o <= '0; per_o <= '0; pul_o <= '0;
      flags_o <= '0;
    end else if (load_i) begin
      ht_o   <= h_total_i;
      hsw_o  <= h_sync_w_i;
      hbp_o  <= h_bp_i;
      hact_o <= h_act_i;
      vbp_o  <= v_bp_i;
      vact_o <= v_act_i;
      per_o  <= per_d;
      pul_o  <= pul_d;
      flags_o <= flags_i;
    end
  end
endmodule

// File: rtl/rgb_tg_counters.sv
module rgb_tg_counters #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11,
  localparam int unsigned PW = HW + VW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [HW-1:0] ht_i,
  input  logic [PW-1:0] per_i,
  input  logic          half_i,
  output logic          load_o,
  output logic          frame_wrap_o,
  output logic [HW-1:0] hcnt_o,
  output logic [PW-1:0] fcnt_o,
  output logic [VW-1:0] line_o,
  output logic          field_o
);
  logic h_wrap;

  assign h_wrap       = ({1'b0, hcnt_o} + 1'b1) >= {1'b0, ht_i};
  assign frame_wrap_o = !load_o && !clr_i && (({1'b0, fcnt_o} + 1'b1) >= {1'b0, per_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= 1'b1; hcnt_o <= '0; fcnt_o <= '0; line_o <= '0; field_o <= 1'b0;
    end else if (clr_i) begin
      load_o <= 1'b1; hcnt_o <= '0; fcnt_o <= '0; line_o <= '0; field_o <= 1'b0;
    end else if (load_o) begin
      load_o <= 1'b0;
    end else begin
      hcnt_o <= h_wrap ? '0 : hcnt_o + 1'b1;
      if (frame_wrap_o) begin
        // frame start outranks a coincident line wrap
        fcnt_o  <= '0;
        line_o  <= '0;
        field_o <= half_i & ~field_o;
      end else begin
        fcnt_o <= fcnt_o + 1'b1;
        line_o <= line_o + VW'(h_wrap);
      end
    end
  end
endmodule

// File: rtl/rgb_tg_decode.sv
module rgb_tg_decode
  import rgb_tg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11,
  localparam int unsigned PW = HW + VW + 1
) (
  input  logic          load_i,
  input  logic [HW-1:0] hcnt_i,
  input  logic [PW-1:0] fcnt_i,
  input  logic [VW-1:0] line_i,
  input  logic [HW-1:0] hsw_i,
  input  logic [HW-1:0] hbp_i,
  input  logic [HW-1:0] hact_i,
  input  logic [VW-1:0] vbp_i,
  input  logic [VW-1:0] vact_i,
  input  logic [PW-1:0] pul_i,
  input  tg_flags_t     flags_i,
  output logic [NSTROBE-1:0] pin_o
);
  logic [HW:0]   h_start;
  logic [HW+1:0] h_end;
  logic [VW:0]   v_end;
  logic in_h, in_v;
  logic [NSTROBE-1:0] act, pol;

  assign h_start = (HW+1)'(hsw_i) + (HW+1)'(hbp_i);
  assign h_end   = (HW+2)'(h_start) + (HW+2)'(hact_i);
  assign v_end   = (VW+1)'(vbp_i) + (VW+1)'(vact_i);
  assign in_h    = ((HW+1)'(hcnt_i) >= h_start) && ((HW+2)'(hcnt_i) < h_end);
  assign in_v    = (line_i >= vbp_i) && ((VW+1)'(line_i) < v_end);

  assign act[IDX_VS] = !load_i && (fcnt_i < pul_i);
  assign act[IDX_HS] = !load_i && (hcnt_i < hsw_i);
  assign act[IDX_DE] = !load_i && flags_i.de_en && in_h && in_v;

  assign pol[IDX_VS] = flags_i.vs_pol;
  assign pol[IDX_HS] = flags_i.hs_pol;
  assign pol[IDX_DE] = flags_i.de_pol;

  for (genvar i = 0; i < NSTROBE; i++) begin : g_pin
    assign pin_o[i] = ~(act[i] ^ pol[i]);
  end
endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
  import rgb_tg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [HW-1:0] h_total_i,
  input  logic [HW-1:0] h_sync_w_i,
  input  logic [HW-1:0] h_bp_i,
  input  logic [HW-1:0] h_act_i,
  input  logic [VW-1:0] v_total_i,
  input  logic [VW-1:0] v_sync_w_i,
  input  logic [VW-1:0] v_bp_i,
  input  logic [VW-1:0] v_act_i,
  input  logic          v_total_unit_i,
  input  logic          vs_w_unit_i,
  input  logic          half_line_i,
  input  logic          vs_pol_i,
  input  logic          hs_pol_i,
  input  logic          de_pol_i,
  input  logic          clk_pol_i,
  input  logic          de_en_i,
  output logic          vsync_o,
  output logic          hsync_o,
  output logic          de_o,
  output logic          launch_rise_o,
  output logic [HW-1:0] px_x_o,
  output logic [VW-1:0] line_y_o,
  output logic          field_o
);
  localparam int unsigned PW = HW + VW + 1;

  tg_flags_t flags_in, flags_q;
  logic load_q, frame_wrap, shadow_ld;
  logic [HW-1:0] ht_q, hsw_q, hbp_q, hact_q;
  logic [VW-1:0] vbp_q, vact_q;
  logic [PW-1:0] per_q, pul_q, fcnt_q;
  logic [NSTROBE-1:0] pins;

  assign flags_in = '{vs_pol: vs_pol_i, hs_pol: hs_pol_i, de_pol: de_pol_i,
                      clk_pol: clk_pol_i, de_en: de_en_i, half: half_line_i};
  assign shadow_ld = !clr_i && (load_q || frame_wrap);

  rgb_tg_shadow #(.HW(HW), .VW(VW)) u_shadow (
    .clk_i, .rst_ni, .load_i(shadow_ld),
    .h_total_i, .h_sync_w_i, .h_bp_i, .h_act_i,
    .v_total_i, .v_sync_w_i, .v_bp_i, .v_act_i,
    .v_total_unit_i, .vs_w_unit_i, .flags_i(flags_in),
    .ht_o(ht_q), .hsw_o(hsw_q), .hbp_o(hbp_q), .hact_o(hact_q),
    .vbp_o(vbp_q), .vact_o(vact_q), .per_o(per_q), .pul_o(pul_q),
    .flags_o(flags_q)
  );

  rgb_tg_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk_i, .rst_ni, .clr_i, .ht_i(ht_q), .per_i(per_q), .half_i(half_line_i),
    .load_o(load_q), .frame_wrap_o(frame_wrap), .hcnt_o(px_x_o),
    .fcnt_o(fcnt_q), .line_o(line_y_o), .field_o(field_o)
  );

  rgb_tg_decode #(.HW(HW), .VW(VW)) u_dec (
    .load_i(load_q), .hcnt_i(px_x_o), .fcnt_i(fcnt_q), .line_i(line_y_o),
    .hsw_i(hsw_q), .hbp_i(hbp_q), .hact_i(hact_q), .vbp_i(vbp_q),
    .vact_i(vact_q), .pul_i(pul_q), .flags_i(flags_q), .pin_o(pins)
  );

  assign vsync_o       = pins[IDX_VS];
  assign hsync_o       = pins[IDX_HS];
  assign de_o          = pins[IDX_DE];
  assign launch_rise_o = flags_q.clk_pol;
endmodule

// File: rtl/rgb_timing_gen_chk.sv
module rgb_timing_gen_chk
  import rgb_tg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          load_q,
  input logic          frame_wrap,
  input tg_flags_t     flags_q,
  input logic          vsync_o,
  input logic          hsync_o,
  input logic          de_o,
  input logic          launch_rise_o,
  input logic [HW-1:0] px_x_o,
  input logic [VW-1:0] line_y_o,
  input logic          field_o
);
  assert_load_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> (hsync_o == !flags_q.hs_pol) && (vsync_o == !flags_q.vs_pol)
               && (px_x_o == '0) && (line_y_o == '0));

  assert_px_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (px_x_o == $past(px_x_o) + 1'b1) || (px_x_o == '0));

  assert_field_plain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_q.half |-> !field_o);

  assert_line_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_wrap |=> (line_y_o == '0));

  assert_de_parked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_q.de_en |-> (de_o == !flags_q.de_pol));

  assert_launch_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_wrap || load_q) |=> $stable(launch_rise_o));
endmodule

bind rgb_timing_gen rgb_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .load_q(load_q),
  .frame_wrap(frame_wrap), .flags_q(flags_q), .vsync_o(vsync_o),
  .hsync_o(hsync_o), .de_o(de_o), .launch_rise_o(launch_rise_o),
  .px_x_o(px_x_o), .line_y_o(line_y_o), .field_o(field_o)
);

// File: tb/rgb_timing_gen_tb.sv
module rgb_timing_gen_tb;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0, rst_ni = 1'b0, clr_i = 1'b0;
  logic [HW-1:0] h_total_i, h_sync_w_i, h_bp_i, h_act_i;
  logic [VW-1:0] v_total_i, v_sync_w_i, v_bp_i, v_act_i;
  logic v_total_unit_i, vs_w_unit_i, half_line_i;
  logic vs_pol_i, hs_pol_i, de_pol_i, clk_pol_i, de_en_i;
  logic vsync_o, hsync_o, de_o, launch_rise_o, field_o;
  logic [HW-1:0] px_x_o;
  logic [VW-1:0] line_y_o;

  always #2 clk = ~clk;

  rgb_timing_gen #(.HW(HW), .VW(VW)) u_dut (
    .clk_i(clk), .rst_ni, .clr_i, .h_total_i, .h_sync_w_i, .h_bp_i, .h_act_i,
    .v_total_i, .v_sync_w_i, .v_bp_i, .v_act_i, .v_total_unit_i, .vs_w_unit_i,
    .half_line_i, .vs_pol_i, .hs_pol_i, .de_pol_i, .clk_pol_i, .de_en_i,
    .vsync_o, .hsync_o, .de_o, .launch_rise_o, .px_x_o, .line_y_o, .field_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, chk_en = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // reference model built from the requirements
  int m_load, m_h, m_f, m_line, m_field;
  int s_ht, s_hsw, s_hbp, s_hact, s_vbp, s_vact, s_per, s_pul;
  int s_half, s_vsp, s_hsp, s_dep, s_clkp, s_den;

  task automatic capture();
    s_ht = h_total_i; s_hsw = h_sync_w_i; s_hbp = h_bp_i; s_hact = h_act_i;
    s_vbp = v_bp_i; s_vact = v_act_i;
    s_per = (v_total_unit_i ? int'(v_total_i) * int'(h_total_i) : int'(v_total_i))
          + (half_line_i ? int'(h_total_i) / 2 : 0);
    s_pul = vs_w_unit_i ? int'(v_sync_w_i) * int'(h_total_i) : int'(v_sync_w_i);
    s_half = half_line_i; s_vsp = vs_pol_i; s_hsp = hs_pol_i; s_dep = de_pol_i;
    s_clkp = clk_pol_i; s_den = de_en_i;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_load = 1; m_h = 0; m_f = 0; m_line = 0; m_field = 0;
      s_ht = 0; s_hsw = 0; s_hbp = 0; s_hact = 0; s_vbp = 0; s_vact = 0;
      s_per = 0; s_pul = 0; s_half = 0; s_vsp = 0; s_hsp = 0; s_dep = 0;
      s_clkp = 0; s_den = 0;
    end else if (clr_i) begin
      m_load = 1; m_h = 0; m_f = 0; m_line = 0; m_field = 0;
    end else if (m_load == 1) begin
      m_load = 0; capture();
    end else begin
      automatic bit lw = (m_h + 1 >= s_ht);
      automatic bit fw = (m_f + 1 >= s_per);
      m_h = lw ? 0 : m_h + 1;
      if (fw) begin
        m_f = 0; m_line = 0; m_field = half_line_i ? 1 - m_field : 0; capture();
      end else begin
        m_f++; m_line += int'(lw);
      end
    end
  end

  function automatic int pin(bit act, int pol);
    return (act ? 1 : 0) == pol ? 1 : 0;
  endfunction

  always @(negedge clk) begin
    if (rst_ni && chk_en && !done) begin
      automatic bit ld = (m_load == 1);
      automatic bit vs = !ld && (m_f < s_pul);
      automatic bit hs = !ld && (m_h < s_hsw);
      automatic bit de = !ld && (s_den == 1) && (m_h >= s_hsw + s_hbp)
                         && (m_h < s_hsw + s_hbp + s_hact)
                         && (m_line >= s_vbp) && (m_line < s_vbp + s_vact);
      chk("R2 px_x", int'(px_x_o), m_h);
      chk("R7 line_y", int'(line_y_o), m_line);
      chk("R3/R4/R5/R9 vsync", int'(vsync_o), pin(vs, s_vsp));
      chk("R2/R9 hsync", int'(hsync_o), pin(hs, s_hsp));
      chk("R8/R10 de", int'(de_o), pin(de, s_dep));
      chk("R6 field", int'(field_o), m_field);
      chk("R11 launch", int'(launch_rise_o), s_clkp);
    end
  end

  task automatic set_cfg(int ht, int hsw, int hbp, int hact, int vt, int vsw, int vbp,
                         int vact, bit vtu, bit vwu, bit half, bit vsp, bit hsp,
                         bit dep, bit ckp, bit den);
    h_total_i = HW'(ht); h_sync_w_i = HW'(hsw); h_bp_i = HW'(hbp); h_act_i = HW'(hact);
    v_total_i = VW'(vt); v_sync_w_i = VW'(vsw); v_bp_i = VW'(vbp); v_act_i = VW'(vact);
    v_total_unit_i = vtu; vs_w_unit_i = vwu; half_line_i = half;
    vs_pol_i = vsp; hs_pol_i = hsp; de_pol_i = dep; clk_pol_i = ckp; de_en_i = den;
  endtask

  task automatic rand_cfg();
    automatic int ht = 4 + int'($urandom_range(16));
    automatic bit vtu = 1'($urandom);
    set_cfg(ht, 1 + int'($urandom_range(2)), int'($urandom_range(2)), int'($urandom_range(ht)),
            vtu ? 2 + int'($urandom_range(6)) : 20 + int'($urandom_range(150)),
            1 + int'($urandom_range(2)), int'($urandom_range(2)), int'($urandom_range(5)),
            vtu, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    set_cfg(10, 2, 1, 5, 60, 3, 1, 3, 0, 0, 0, 0, 0, 0, 0, 1);
    step(3);
    rst_ni = 1'b1;
    chk_en = 1;
    // R1: load cycle right after reset, strobes at default inactive level
    chk("R1 vsync idle", int'(vsync_o), 1);
    chk("R1 hsync idle", int'(hsync_o), 1);
    chk("R1 de idle", int'(de_o), 1);
    chk("R1 px zero", int'(px_x_o), 0);
    step(1);
    // R2/R3: first pixel of frame, both syncs active low
    chk("R2 hsync start", int'(hsync_o), 0);
    chk("R3 vsync start", int'(vsync_o), 0);
    step(200);

    // R4/R5 line units: frame boundaries coincide with line wraps (R7)
    set_cfg(8, 2, 1, 4, 5, 2, 1, 2, 1, 1, 0, 0, 0, 0, 0, 1);
    step(200);

    // R6 half line: frame = 4*10 + 5 = 45 clocks
    set_cfg(10, 2, 1, 5, 4, 1, 0, 3, 1, 1, 1, 0, 0, 0, 0, 1);
    step(100);
    begin
      automatic logic f0 = field_o;
      automatic int n = 0;
      while (field_o == f0) step(1);
      f0 = field_o;
      while (field_o == f0) begin step(1); n++; end
      chk("R6 field period", n, 45);
    end

    // R9 all polarities high, R10 data enable off, R11 rising launch
    set_cfg(12, 3, 1, 6, 90, 4, 1, 3, 0, 0, 0, 1, 1, 1, 1, 0);
    step(300);
    chk("R11 launch rise", int'(launch_rise_o), 1);
    chk("R10 de parked", int'(de_o), 0);

    // R12: mid-frame change; hsync width stays old until next frame
    set_cfg(10, 2, 0, 5, 100, 2, 0, 4, 0, 0, 0, 0, 0, 0, 0, 1);
    step(150);
    while (!(line_y_o == 1 && px_x_o == 0)) step(1);
    h_sync_w_i = 6;
    step(2);
    chk("R12 hsync held", int'(hsync_o), 1);
    step(200);

    // R1 synchronous restart mid-frame
    step(17);
    clr_i = 1'b1; step(1); clr_i = 1'b0;
    chk("R1 clr load px", int'(px_x_o), 0);
    step(1);
    chk("R1 clr restart px", int'(px_x_o), 0);
    step(100);

    // random configurations with mid-frame changes and occasional restarts
    for (int s = 0; s < 40; s++) begin
      rand_cfg();
      for (int c = 0; c < 300; c++) begin
        step(1);
        if ($urandom_range(99) == 0) rand_cfg();
        if ($urandom_range(399) == 0) begin clr_i = 1'b1; step(1); clr_i = 1'b0; end
      end
    end
    finish_run();
  end
endmodule